// File: doc/BRIEF.md
# Predictive Read-Retry Controller

This block sequences page reads for a multi-level-cell NAND flash controller whose cells lose charge over time. It holds one predicted read reference code for each flash block. A host read issues its first array read at that predicted code. Each time the ECC decoder reports the page uncorrectable, the block lowers the code by one and reads again. A read ends on the first ECC pass, when the retry budget is spent, or when the code has reached its floor.

A periodic tick starts a background refresh pass over every block. For each block the pass reads page 0 at a series of codes. It starts at the stored prediction and moves downward, because retention loss only ever lowers the best code. It keeps the code that gave the lowest reported error count and writes that code back as the block's new prediction.

Host reads take priority over the refresh pass. A host request that arrives mid-pass is served next. The block whose scan it cut off keeps its old prediction, and the pass continues with the following block. The flash array and the ECC decoder are outside this block.

Top module: `prr_ctrl`

## Requirements
- R1: Each flash block has exactly one stored prediction, and every entry holds VREF_INIT after reset.
- R2: A host read's first flash command carries the requested block and page and the block's stored prediction, with the background flag low.
- R3: When ECC reports fail on a host read, the next command for that read uses a code one lower. When ECC reports pass, the read completes with rd_ok=1, rd_retries equal to the number of re-reads, and rd_vref equal to the code that passed.
- R4: A host read that fails after RETRY_LIMIT re-reads completes with rd_ok=0 and rd_retries=RETRY_LIMIT.
- R5: No command ever carries a code below VREF_MIN. A host read that fails at VREF_MIN completes at once with rd_ok=0.
- R6: A tick while no refresh pass is running starts a pass that visits blocks 0 to NUM_BLOCKS-1 in ascending order, reading page 0 with the background flag high. A tick during a pass has no effect.
- R7: For each block, the pass reads codes from the stored prediction downward, one code apart. It reads SWEEP_STEPS codes, or fewer if VREF_MIN comes first. It never reads above the prediction, and it stores the code with the lowest error count.
- R8: When several scanned codes share the lowest error count, the highest of them is stored.
- R9: A host request that arrives during a pass is served before the next background read. A block whose scan it interrupts keeps its prediction, and the pass continues at the next block.
- R10: At most one flash command is outstanding. No new command is issued until the ECC response to the previous one arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Host read request, held until rd_done |
| rd_block | input | BLK_W | Block of the host read |
| rd_page | input | PAGE_W | Page of the host read |
| refresh_tick | input | 1 | Periodic trigger for the refresh pass |
| ecc_valid | input | 1 | ECC result for the outstanding command |
| ecc_pass | input | 1 | 1 when the page was correctable |
| ecc_errs | input | ERR_W | Raw bit error count of the read |
| fl_cmd_valid | output | 1 | One-cycle flash read command |
| fl_cmd_block | output | BLK_W | Block to read |
| fl_cmd_page | output | PAGE_W | Page to read |
| fl_cmd_vref | output | VREF_W | Reference code for the read |
| fl_cmd_bg | output | 1 | 1 for a refresh-pass read |
| rd_done | output | 1 | One-cycle completion of a host read |
| rd_ok | output | 1 | Host read ended with ECC pass |
| rd_retries | output | RTY_W | Re-reads used by the host read |
| rd_vref | output | VREF_W | Last code used by the host read |

## Verification
The bench drives a block whose ECC passes only after a few downward steps, a block whose best code is far below the retry window, a block with a flat error profile, and a block whose scan window is clipped by VREF_MIN. If the step direction or the stop order were wrong, the retry counts and final codes would differ from the arithmetic model. A tie rule using <= would store the lowest flat code instead of the highest. A missing floor clamp would let a read go below VREF_MIN. The bench also cuts into a pass with a host read. A design that finished or committed the interrupted block would change that block's next first-read code, and a design that restarted the pass or re-armed it on a second tick would issue the wrong number of background reads.

// File: rtl/prr_pkg.sv
package prr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HWAIT = 2'd1,
        ST_SWAIT = 2'd2
    } prr_state_e;
endpackage

// File: rtl/prr_pred_table.sv
module prr_pred_table #(
    parameter int NUM = 16,
    parameter int W   = 8,
    parameter int INIT = 128,
    localparam int AW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] ent_q [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_ent
        logic [W-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[i];
            if (wr_en && (wr_addr == AW'(i))) ent_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[i] <= W'(INIT);
            else        ent_q[i] <= ent_d;
        end
    end

    assign rd_data = ent_q[rd_addr];
endmodule

// File: rtl/prr_best_track.sv
module prr_best_track #(
    parameter int VREF_W = 8,
    parameter int ERR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              first,
    input  logic [VREF_W-1:0] code,
    input  logic [ERR_W-1:0]  errs,
    output logic [VREF_W-1:0] nxt_code
);
    typedef struct packed {
        logic [VREF_W-1:0] code;
        logic [ERR_W-1:0]  errs;
    } best_t;

    best_t q, d;

    always_comb begin
        d = q;
        // strict less-than: an equal count keeps the earlier, higher code
        if (smp && (first || (errs < q.errs))) begin
            d.code = code;
            d.errs = errs;
        end
        nxt_code = d.code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r8_tie_keeps_higher: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !first && errs >= q.errs) |=> $stable(q.code));

    a_r7_best_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !first) |=> (q.errs <= $past(q.errs)));
endmodule

// File: rtl/prr_ctrl.sv
module prr_ctrl
    import prr_pkg::*;
#(
    parameter int NUM_BLOCKS  = 16,
    parameter int PAGE_W      = 8,
    parameter int VREF_W      = 8,
    parameter int ERR_W       = 10,
    parameter int RETRY_LIMIT = 8,
    parameter int SWEEP_STEPS = 8,
    parameter int VREF_INIT   = 128,
    parameter int VREF_MIN    = 8,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int RTY_W = $clog2(RETRY_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [BLK_W-1:0]  rd_block,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic              refresh_tick,
    input  logic              ecc_valid,
    input  logic              ecc_pass,
    input  logic [ERR_W-1:0]  ecc_errs,
    output logic              fl_cmd_valid,
    output logic [BLK_W-1:0]  fl_cmd_block,
    output logic [PAGE_W-1:0] fl_cmd_page,
    output logic [VREF_W-1:0] fl_cmd_vref,
    output logic              fl_cmd_bg,
    output logic              rd_done,
    output logic              rd_ok,
    output logic [RTY_W-1:0]  rd_retries,
    output logic [VREF_W-1:0] rd_vref
);
    localparam int CNT_W = $clog2(SWEEP_STEPS + 1);
    localparam logic [VREF_W-1:0] MIN_C   = VREF_W'(VREF_MIN);
    localparam logic [RTY_W-1:0]  LIMIT_C = RTY_W'(RETRY_LIMIT);
    localparam logic [CNT_W-1:0]  LAST_C  = CNT_W'(SWEEP_STEPS - 1);
    localparam logic [BLK_W-1:0]  BLK_LAST = BLK_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        prr_state_e        st;
        logic [BLK_W-1:0]  h_blk;
        logic [PAGE_W-1:0] h_page;
        logic [VREF_W-1:0] h_vref;
        logic [RTY_W-1:0]  h_retry;
        logic              sw_on;
        logic              sw_started;
        logic [BLK_W-1:0]  sw_blk;
        logic [VREF_W-1:0] sw_code;
        logic [VREF_W-1:0] sw_start;
        logic [CNT_W-1:0]  sw_cnt;
        logic              cmd_valid;
        logic [BLK_W-1:0]  cmd_blk;
        logic [PAGE_W-1:0] cmd_page;
        logic [VREF_W-1:0] cmd_vref;
        logic              cmd_bg;
        logic              done;
        logic              ok;
        logic [RTY_W-1:0]  retries;
        logic [VREF_W-1:0] done_vref;
    } ctl_t;

    ctl_t q, d;

    logic [BLK_W-1:0]  tbl_addr;
    logic [VREF_W-1:0] tbl_rd;
    logic              tbl_we;
    logic [VREF_W-1:0] trk_nxt;
    logic              trk_smp;
    logic              trk_first;
    logic              sw_last;
    logic              blk_end;
    logic [VREF_W-1:0] sw_use;

    prr_pred_table #(
        .NUM  (NUM_BLOCKS),
        .W    (VREF_W),
        .INIT (VREF_INIT)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (tbl_addr),
        .rd_data (tbl_rd),
        .wr_en   (tbl_we),
        .wr_addr (q.sw_blk),
        .wr_data (trk_nxt)
    );

    prr_best_track #(
        .VREF_W (VREF_W),
        .ERR_W  (ERR_W)
    ) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (trk_smp),
        .first    (trk_first),
        .code     (q.sw_code),
        .errs     (ecc_errs),
        .nxt_code (trk_nxt)
    );

    always_comb begin
        d           = q;
        d.cmd_valid = 1'b0;
        d.done      = 1'b0;
        tbl_addr    = q.sw_blk;
        tbl_we      = 1'b0;
        trk_smp     = 1'b0;
        trk_first   = (q.sw_cnt == '0);
        sw_last     = (q.sw_blk == BLK_LAST);
        blk_end     = (q.sw_cnt == LAST_C) || (q.sw_code == MIN_C);
        sw_use      = q.sw_started ? q.sw_code : tbl_rd;

        if (refresh_tick && !q.sw_on) begin
            d.sw_on      = 1'b1;
            d.sw_blk     = '0;
            d.sw_started = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (rd_req) begin
                    tbl_addr = rd_block;
                    if (q.sw_on && q.sw_started) begin
                        d.sw_started = 1'b0;
                        if (sw_last) d.sw_on  = 1'b0;
                        else         d.sw_blk = q.sw_blk + 1'b1;
                    end
                    d.h_blk     = rd_block;
                    d.h_page    = rd_page;
                    d.h_vref    = tbl_rd;
                    d.h_retry   = '0;
                    d.cmd_valid = 1'b1;
                    d.cmd_blk   = rd_block;
                    d.cmd_page  = rd_page;
                    d.cmd_vref  = tbl_rd;
                    d.cmd_bg    = 1'b0;
                    d.st        = ST_HWAIT;
                end else if (q.sw_on) begin
                    if (!q.sw_started) begin
                        d.sw_start   = tbl_rd;
                        d.sw_cnt     = '0;
                        d.sw_started = 1'b1;
                    end
                    d.sw_code   = sw_use;
                    d.cmd_valid = 1'b1;
                    d.cmd_blk   = q.sw_blk;
                    d.cmd_page  = '0;
                    d.cmd_vref  = sw_use;
                    d.cmd_bg    = 1'b1;
                    d.st        = ST_SWAIT;
                end
            end
            ST_HWAIT: begin
                if (ecc_valid) begin
                    if (ecc_pass || (q.h_retry == LIMIT_C) || (q.h_vref == MIN_C)) begin
                        d.done      = 1'b1;
                        d.ok        = ecc_pass;
                        d.retries   = q.h_retry;
                        d.done_vref = q.h_vref;
                        d.st        = ST_IDLE;
                    end else begin
                        d.h_vref    = q.h_vref - 1'b1;
                        d.h_retry   = q.h_retry + 1'b1;
                        d.cmd_valid = 1'b1;
                        d.cmd_blk   = q.h_blk;
                        d.cmd_page  = q.h_page;
                        d.cmd_vref  = q.h_vref - 1'b1;
                        d.cmd_bg    = 1'b0;
                    end
                end
            end
            ST_SWAIT: begin
                if (ecc_valid) begin
                    trk_smp = 1'b1;
                    if (blk_end) begin
                        tbl_we       = 1'b1;
                        d.sw_started = 1'b0;
                        if (sw_last) d.sw_on  = 1'b0;
                        else         d.sw_blk = q.sw_blk + 1'b1;
                    end else begin
                        d.sw_code = q.sw_code - 1'b1;
                        d.sw_cnt  = q.sw_cnt + 1'b1;
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fl_cmd_valid = q.cmd_valid;
    assign fl_cmd_block = q.cmd_blk;
    assign fl_cmd_page  = q.cmd_page;
    assign fl_cmd_vref  = q.cmd_vref;
    assign fl_cmd_bg    = q.cmd_bg;
    assign rd_done      = q.done;
    assign rd_ok        = q.ok;
    assign rd_retries   = q.retries;
    assign rd_vref      = q.done_vref;

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cmd_valid |=> !fl_cmd_valid);

    a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cmd_valid |-> (fl_cmd_vref >= MIN_C));

    a_r7_no_climb: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && fl_cmd_bg) |-> (fl_cmd_vref <= q.sw_start));

    a_r7_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> ((trk_nxt <= q.sw_start) && (trk_nxt >= MIN_C)));

    a_r4_retry_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rd_retries <= LIMIT_C));

    a_r3_ok_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_ok) |-> $past(ecc_valid && ecc_pass));
endmodule

// File: tb/prr_ctrl_bench.sv
module prr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int RL   = 5;
    localparam int SS   = 6;
    localparam int INIT = 40;
    localparam int VMIN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0;
    logic [1:0] rd_block = '0;
    logic [7:0] rd_page = '0;
    logic       refresh_tick = 1'b0;
    logic       ecc_valid = 1'b0;
    logic       ecc_pass = 1'b0;
    logic [9:0] ecc_errs = '0;
    logic       fl_cmd_valid;
    logic [1:0] fl_cmd_block;
    logic [7:0] fl_cmd_page;
    logic [7:0] fl_cmd_vref;
    logic       fl_cmd_bg;
    logic       rd_done;
    logic       rd_ok;
    logic [2:0] rd_retries;
    logic [7:0] rd_vref;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prr_ctrl #(
        .NUM_BLOCKS (NB), .PAGE_W (8), .VREF_W (8), .ERR_W (10),
        .RETRY_LIMIT (RL), .SWEEP_STEPS (SS), .VREF_INIT (INIT), .VREF_MIN (VMIN)
    ) u_prr_ctrl (
        .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_block (rd_block),
        .rd_page (rd_page), .refresh_tick (refresh_tick), .ecc_valid (ecc_valid),
        .ecc_pass (ecc_pass), .ecc_errs (ecc_errs), .fl_cmd_valid (fl_cmd_valid),
        .fl_cmd_block (fl_cmd_block), .fl_cmd_page (fl_cmd_page),
        .fl_cmd_vref (fl_cmd_vref), .fl_cmd_bg (fl_cmd_bg), .rd_done (rd_done),
        .rd_ok (rd_ok), .rd_retries (rd_retries), .rd_vref (rd_vref)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // flash/ECC stub state
    int  opt [NB];
    bit  flat [NB];
    int  mp [NB];          // bench model of stored predictions
    bit  pend = 0;
    int  pend_err = 0;
    bit  want_first = 0;
    int  first_vref = 0;
    int  first_page = 0;
    int  first_bg = 0;
    int  bg_cnt = 0;
    int  bg_bad = 0;       // bg reads off page 0 or out of block order
    int  bg_last_blk = 0;
    bit  watch_next_bg = 0;
    int  next_bg_blk = -1;
    int  host_cmds = 0;

    function automatic int err_of(int b, int v);
        if (flat[b]) return 10;
        return (v > opt[b]) ? (v - opt[b]) * 4 : (opt[b] - v) * 4;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
    end

    initial begin : responder
        forever begin
            @(negedge clk);
            if (pend) begin
                ecc_valid = 1'b1;
                ecc_errs  = 10'(pend_err);
                ecc_pass  = (pend_err <= 4);
                pend = 0;
            end else begin
                ecc_valid = 1'b0;
            end
            if (fl_cmd_valid) begin
                pend = 1;
                pend_err = err_of(int'(fl_cmd_block), int'(fl_cmd_vref));
                if (fl_cmd_bg) begin
                    if (fl_cmd_page != 8'd0) bg_bad++;
                    if (bg_cnt > 0 && int'(fl_cmd_block) < bg_last_blk) bg_bad++;
                    bg_last_blk = int'(fl_cmd_block);
                    bg_cnt++;
                    if (watch_next_bg) begin
                        next_bg_blk = int'(fl_cmd_block);
                        watch_next_bg = 0;
                    end
                end else begin
                    host_cmds++;
                    if (want_first) begin
                        first_vref = int'(fl_cmd_vref);
                        first_page = int'(fl_cmd_page);
                        first_bg   = int'(fl_cmd_bg);
                        want_first = 0;
                    end
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_read(int b, output bit ok, output int rt, output int v);
        v = mp[b]; rt = 0; ok = 0;
        forever begin
            if (err_of(b, v) <= 4) begin ok = 1; return; end
            if (rt == RL || v == VMIN) return;
            v--; rt++;
        end
    endtask

    function automatic int model_sweep(int b);
        int v, best, be, n;
        v = mp[b]; best = v; be = err_of(b, v); n = 1;
        while (n < SS && v > VMIN) begin
            v--; n++;
            if (err_of(b, v) < be) begin be = err_of(b, v); best = v; end
        end
        return best;
    endfunction

    function automatic int sweep_len(int b);
        int n = mp[b] - VMIN + 1;
        return (n < SS) ? n : SS;
    endfunction

    task automatic host_read(int b, int pg);
        bit eok; int ert, ev;
        model_read(b, eok, ert, ev);
        want_first = 1;
        rd_block = 2'(b); rd_page = 8'(pg); rd_req = 1'b1;
        do @(negedge clk); while (!rd_done);
        rd_req = 1'b0;
        chk(first_vref == mp[b], "R2 first code is stored prediction (R1 after reset)", first_vref, mp[b]);
        chk(first_page == pg && first_bg == 0, "R2 first command page", first_page, pg);
        chk(rd_ok == eok, "R3/R4/R5 read outcome", int'(rd_ok), int'(eok));
        chk(int'(rd_retries) == ert, "R3/R4 retry count", int'(rd_retries), ert);
        chk(int'(rd_vref) == ev, "R3/R5 final code", int'(rd_vref), ev);
    endtask

    task automatic tick();
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        int last = bg_cnt;
        while (q < 12) begin
            @(negedge clk);
            if (bg_cnt != last) begin q = 0; last = bg_cnt; end
            else q++;
        end
    endtask

    initial begin : watchdog
        wait (cyc > 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        int exp_cnt;
        opt[0] = 40; opt[1] = 37; opt[2] = 20; opt[3] = 0;
        flat[0] = 0; flat[1] = 0; flat[2] = 0; flat[3] = 1;
        for (int b = 0; b < NB; b++) mp[b] = INIT;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fl_cmd_valid == 0 && rd_done == 0, "R1 reset state quiet", int'(fl_cmd_valid), 0);

        // R1..R4: reads at the reset prediction
        host_read(0, 5);   // passes at once
        host_read(1, 9);   // passes after steps down (R3)
        host_read(2, 17);  // runs out of retries (R4)
        host_read(3, 2);   // flat profile, retries exhausted (R4)

        // R6/R7/R8: first refresh pass, with an ignored second tick
        bg_cnt = 0; exp_cnt = 0;
        for (int b = 0; b < NB; b++) exp_cnt += sweep_len(b);
        tick();
        repeat (5) @(negedge clk);
        tick();            // R6: must not restart or extend the pass
        wait_quiet();
        chk(bg_cnt == exp_cnt, "R6 one pass, second tick ignored", bg_cnt, exp_cnt);
        chk(bg_bad == 0, "R6 page 0 and ascending block order", bg_bad, 0);
        for (int b = 0; b < NB; b++) mp[b] = model_sweep(b);
        host_read(0, 1);   // R7 prediction kept at optimum
        host_read(1, 1);   // R7 moved down to optimum
        host_read(2, 1);   // R7 lowest code of window
        host_read(3, 1);   // R8 flat: highest code kept

        // second pass: block 2 window clipped at the floor (R5/R7)
        bg_cnt = 0; exp_cnt = 0;
        for (int b = 0; b < NB; b++) exp_cnt += sweep_len(b);
        tick();
        wait_quiet();
        chk(bg_cnt == exp_cnt, "R7 window clipped at VREF_MIN", bg_cnt, exp_cnt);
        for (int b = 0; b < NB; b++) mp[b] = model_sweep(b);
        host_read(2, 7);   // R5 fails at floor with no retry
        host_read(1, 7);

        // R9: host read cuts into the pass during block 0
        opt[0] = 34;
        bg_cnt = 0;
        exp_cnt = 1;
        for (int b = 1; b < NB; b++) exp_cnt += sweep_len(b);
        tick();
        while (bg_cnt == 0) @(negedge clk);
        watch_next_bg = 1;
        host_read(1, 3);
        wait_quiet();
        chk(next_bg_blk == 1, "R9 pass resumes at next block", next_bg_blk, 1);
        chk(bg_cnt == exp_cnt, "R9 interrupted block not rescanned", bg_cnt, exp_cnt);
        for (int b = 1; b < NB; b++) mp[b] = model_sweep(b);
        host_read(0, 4);   // R9 block 0 keeps prediction 40
        host_read(2, 4);
        host_read(3, 4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule